// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protection Guard

This block keeps the status register of a serial flash device and decides whether program and erase work may go ahead. The register holds six live bits: a busy flag, a write-enable latch, a two-bit protection level, an auto-increment programming flag and a lock bit. A command layer sits in front of the block. It presents one strobe for each instruction that has completed, together with the opcode and, for a status write, the data byte. An array engine reports busy, operation launch and the end of auto-increment programming.

A status write takes effect only when the instruction just before it was the arming opcode. It is further qualified by the write-protect pin (active low) and the lock bit. The protection level marks an upper slice of the array as read-only. For any target address the block gives a program/erase permit, and it gives a separate permit for erasing the whole array.

The status byte is a combinational view of the registers, so repeated status reads during a busy period always show current values.

Top module: `stat_guard`

## Requirements
- R1: After reset the status byte reads 0x0C: protection level 11, lock 0, auto-increment 0, write-enable latch 0, busy 0. Bit layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level (bit 3 high, bit 2 low), bits 5:4 always 0, bit 6 auto-increment, bit 7 lock.
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears both the latch and the auto-increment bit.
- R3: A status write (opcode 0x01) changes the register only if the instruction strobed immediately before it was 0x50. Any other instruction in between, or a second 0x01, uses up the arming.
- R4: With wp_n low and the lock bit at 1, an armed status write leaves bits 7 and 3:2 unchanged.
- R5: With wp_n high, an armed status write copies data bits 7 and 3:2 into lock and protection, and this includes clearing the lock.
- R6: With wp_n low and the lock at 0, one armed status write can set the lock and change the protection level together.
- R7: addr_ok is 1 only when the latch is set and the address lies outside the protected region. Level 00 protects nothing, 01 protects the top quarter, 10 the top half and 11 everything.
- R8: chip_ok is 1 only when the latch is set and the protection level is 00.
- R9: The busy bit follows busy_in one clock later. Bits 5:4 always read 0.
- R10: A launch pulse with op_is_aai set sets the auto-increment bit and keeps the latch. A launch pulse with op_is_aai clear clears the latch.
- R11: An aai_end pulse clears both the auto-increment bit and the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_stb | input | 1 | One-cycle pulse: an instruction has completed |
| instr_op | input | 8 | Opcode of the completed instruction |
| instr_data | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| busy_in | input | 1 | Internal operation in progress |
| op_launch | input | 1 | Pulse: the engine has started a program or erase |
| op_is_aai | input | 1 | Qualifies op_launch as an auto-increment program |
| aai_end | input | 1 | Pulse: auto-increment programming has run off the array end |
| chk_addr | input | ADDR_W | Address to test for write permission |
| status_byte | output | 8 | Current status register |
| addr_ok | output | 1 | Program/erase permitted at chk_addr |
| chip_ok | output | 1 | Whole-array erase permitted |

## Verification
The address permit is swept over every address of an 8-bit array, for each of the four protection levels and both latch states. This exposes a wrong quarter or half boundary and any permit that leaks through while the latch is clear.

Status writes are tried over every combination of pin level, starting lock value and a set of data bytes. This separates the refused case from the lock-set-only case and from the fully open case.

Arming is tried in three ways: directly before the write, with another instruction in between, and with two writes back to back. These show whether the arm is kept only for the single following instruction.

The engine pulses are applied one at a time, so that each effect on the latch and the auto-increment bit can be checked on its own.

// File: rtl/stg_pkg.sv
package stg_pkg;

    localparam logic [7:0] OP_ARM   = 8'h50;
    localparam logic [7:0] OP_WRST  = 8'h01;
    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;

    typedef struct packed {
        logic       lock;
        logic       aai;
        logic [1:0] rsv;
        logic [1:0] lvl;
        logic       wel;
        logic       busy;
    } stat_t;

    localparam stat_t STAT_RESET = '{lock: 1'b0, aai: 1'b0, rsv: 2'b00,
                                     lvl: 2'b11, wel: 1'b0, busy: 1'b0};

    typedef enum logic [1:0] {
        LVL_NONE = 2'b00,
        LVL_QTR  = 2'b01,
        LVL_HALF = 2'b10,
        LVL_ALL  = 2'b11
    } lvl_e;

    function automatic logic wr_allowed(input logic pin_n, input logic lock);
        return pin_n | ~lock;
    endfunction

endpackage

// File: rtl/stg_arm.sv
module stg_arm
    import stg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_stb,
    input  logic [7:0] instr_op,
    output logic       wr_go
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (instr_stb)
            armed_q <= (instr_op == OP_ARM);
    end

    assign wr_go = instr_stb && (instr_op == OP_WRST) && armed_q;

    // R3
    arm_spent_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_stb && instr_op != OP_ARM) |=> !armed_q);

    // R3
    arm_needs_prior_chk: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> $past(instr_op) == OP_ARM);
endmodule

// File: rtl/stg_regs.sv
module stg_regs
    import stg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       instr_stb,
    input  logic [7:0] instr_op,
    input  logic       wr_go,
    input  logic       new_lock,
    input  logic [1:0] new_lvl,
    input  logic       wp_n,
    input  logic       busy_in,
    input  logic       op_launch,
    input  logic       op_is_aai,
    input  logic       aai_end,
    output stat_t      stat
);
    stat_t st_q;
    logic  apply;

    assign apply = wr_go && wr_allowed(wp_n, st_q.lock);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= STAT_RESET;
        end else begin
            st_q.busy <= busy_in;
            st_q.rsv  <= 2'b00;
            if (apply) begin
                st_q.lock <= new_lock;
                st_q.lvl  <= new_lvl;
            end
            if (instr_stb && instr_op == OP_WDIS) begin
                st_q.wel <= 1'b0;
                st_q.aai <= 1'b0;
            end else if (aai_end) begin
                st_q.wel <= 1'b0;
                st_q.aai <= 1'b0;
            end else if (op_launch) begin
                if (op_is_aai)
                    st_q.aai <= 1'b1;
                else
                    st_q.wel <= 1'b0;
            end else if (instr_stb && instr_op == OP_WEN) begin
                st_q.wel <= 1'b1;
            end
        end
    end

    assign stat = st_q;

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && st_q.lock) |=> st_q.lock);

    // R3
    unarmed_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_stb && instr_op == OP_WRST && !wr_go) |=> $stable(st_q.lvl));

    // R2
    wen_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_stb && instr_op == OP_WEN && !op_launch && !aai_end) |=> st_q.wel);

    // R9
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.rsv == 2'b00);
endmodule

// File: rtl/stg_prot.sv
module stg_prot
    import stg_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        lvl,
    input  logic              wel,
    output logic              addr_ok,
    output logic              chip_ok
);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);

    logic hit;

    always_comb begin
        unique case (lvl_e'(lvl))
            LVL_NONE: hit = 1'b0;
            LVL_QTR:  hit = (addr >= QTR_BASE);
            LVL_HALF: hit = (addr >= HALF_BASE);
            default:  hit = 1'b1;
        endcase
    end

    assign addr_ok = wel && !hit;
    assign chip_ok = wel && (lvl == 2'b00);
endmodule

// File: rtl/stat_guard.sv
module stat_guard
    import stg_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_stb,
    input  logic [7:0]        instr_op,
    input  logic [7:0]        instr_data,
    input  logic              wp_n,
    input  logic              busy_in,
    input  logic              op_launch,
    input  logic              op_is_aai,
    input  logic              aai_end,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        status_byte,
    output logic              addr_ok,
    output logic              chip_ok
);
    stat_t st;
    stat_t wr_img;
    logic  wr_go;
    logic  unused_data;

    assign wr_img      = stat_t'(instr_data);
    assign unused_data = ^{wr_img.aai, wr_img.rsv, wr_img.wel, wr_img.busy};

    stg_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .instr_stb (instr_stb),
        .instr_op  (instr_op),
        .wr_go     (wr_go)
    );

    stg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .instr_stb (instr_stb),
        .instr_op  (instr_op),
        .wr_go     (wr_go),
        .new_lock  (wr_img.lock),
        .new_lvl   (wr_img.lvl),
        .wp_n      (wp_n),
        .busy_in   (busy_in),
        .op_launch (op_launch),
        .op_is_aai (op_is_aai),
        .aai_end   (aai_end),
        .stat      (st)
    );

    stg_prot #(.ADDR_W(ADDR_W)) u_prot (
        .addr    (chk_addr),
        .lvl     (st.lvl),
        .wel     (st.wel),
        .addr_ok (addr_ok),
        .chip_ok (chip_ok)
    );

    assign status_byte = st;

    // R8
    chip_implies_addr_chk: assert property (@(posedge clk) disable iff (rst)
        chip_ok |-> addr_ok);

    // R7
    full_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (status_byte[3:2] == 2'b11) |-> !addr_ok);

    // R7
    no_wel_chk: assert property (@(posedge clk) disable iff (rst)
        !status_byte[1] |-> (!addr_ok && !chip_ok));

    // R9
    busy_follow_chk: assert property (@(posedge clk) disable iff (rst)
        busy_in |=> status_byte[0]);
endmodule

// File: tb/stat_guard_test.sv
module stat_guard_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_stb = 1'b0;
    logic [7:0]    instr_op = 8'h00;
    logic [7:0]    instr_data = 8'h00;
    logic          wp_n = 1'b1;
    logic          busy_in = 1'b0;
    logic          op_launch = 1'b0;
    logic          op_is_aai = 1'b0;
    logic          aai_end = 1'b0;
    logic [AW-1:0] chk_addr = '0;
    logic [7:0]    status_byte;
    logic          addr_ok;
    logic          chip_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    stat_guard #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .instr_stb(instr_stb), .instr_op(instr_op),
        .instr_data(instr_data), .wp_n(wp_n), .busy_in(busy_in),
        .op_launch(op_launch), .op_is_aai(op_is_aai), .aai_end(aai_end),
        .chk_addr(chk_addr), .status_byte(status_byte),
        .addr_ok(addr_ok), .chip_ok(chip_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic instr(input logic [7:0] op, input logic [7:0] d);
        @(negedge clk);
        instr_stb = 1'b1; instr_op = op; instr_data = d;
        @(negedge clk);
        instr_stb = 1'b0;
        #1;
    endtask

    task automatic pulse_launch(input logic aai);
        @(negedge clk);
        op_launch = 1'b1; op_is_aai = aai;
        @(negedge clk);
        op_launch = 1'b0; op_is_aai = 1'b0;
        #1;
    endtask

    task automatic load_status(input logic [7:0] d);
        wp_n = 1'b1;
        instr(8'h50, 8'h00);
        instr(8'h01, d);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 reset", status_byte, 8'h0C);

        // R2 write enable
        instr(8'h06, 8'h00);
        check("R2 wren", status_byte[1], 1);
        // R10 aai launch keeps latch, sets aai
        pulse_launch(1'b1);
        check("R10 aai launch", status_byte & 8'h42, 8'h42);
        // R2 write disable clears both
        instr(8'h04, 8'h00);
        check("R2 wrdi", status_byte & 8'h42, 8'h00);
        // R10 plain launch clears latch
        instr(8'h06, 8'h00);
        pulse_launch(1'b0);
        check("R10 plain launch", status_byte & 8'h42, 8'h00);
        // R11 aai end
        instr(8'h06, 8'h00);
        pulse_launch(1'b1);
        @(negedge clk); aai_end = 1'b1;
        @(negedge clk); aai_end = 1'b0; #1;
        check("R11 aai end", status_byte & 8'h42, 8'h00);

        // R3 arming rules
        instr(8'h01, 8'h00);
        check("R3 unarmed", status_byte[3:2], 2'b11);
        instr(8'h50, 8'h00);
        instr(8'h06, 8'h00);
        instr(8'h01, 8'h00);
        check("R3 arm wasted", status_byte[3:2], 2'b11);
        instr(8'h50, 8'h00);
        instr(8'h01, 8'h04);
        check("R3 armed", status_byte[3:2], 2'b01);
        instr(8'h01, 8'h08);
        check("R3 second write", status_byte[3:2], 2'b01);

        // R4 R5 R6 pin/lock matrix
        for (int w = 0; w < 2; w++) begin
            for (int lk = 0; lk < 2; lk++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] d;
                    logic [7:0] start;
                    logic [7:0] exp;
                    d = (k == 0) ? 8'h00 : (k == 1) ? 8'h84 : (k == 2) ? 8'h8C : 8'h08;
                    start = lk ? 8'h8C : 8'h0C;
                    load_status(start);
                    wp_n = w[0];
                    instr(8'h50, 8'h00);
                    instr(8'h01, d);
                    exp = (w == 1 || lk == 0) ? (d & 8'h8C) : start;
                    if (w == 1)
                        check("R5 pin high", status_byte & 8'h8C, exp);
                    else if (lk == 1)
                        check("R4 locked", status_byte & 8'h8C, exp);
                    else
                        check("R6 lock and level", status_byte & 8'h8C, exp);
                end
            end
        end

        // R7 R8 address sweep
        for (int lv = 0; lv < 4; lv++) begin
            for (int we = 0; we < 2; we++) begin
                load_status(8'(lv << 2));
                instr(we ? 8'h06 : 8'h04, 8'h00);
                check("R8 chip permit", chip_ok, (we == 1 && lv == 0) ? 1 : 0);
                for (int a = 0; a < (1 << AW); a++) begin
                    bit prot;
                    chk_addr = AW'(a);
                    #1;
                    prot = (lv == 3) || (lv == 2 && a >= 128) || (lv == 1 && a >= 192);
                    check("R7 addr permit", addr_ok, (we == 1 && !prot) ? 1 : 0);
                end
            end
        end

        // R9 busy follows, reserved bits zero
        @(negedge clk); busy_in = 1'b1;
        #1;
        check("R9 busy not yet", status_byte[0], 0);
        @(negedge clk); #1;
        check("R9 busy set", status_byte[0], 1);
        check("R9 reserved", status_byte[5:4], 0);
        busy_in = 1'b0;
        @(negedge clk); #1;
        check("R9 busy clear", status_byte[0], 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule